// File: doc/BRIEF.md
# ADC Scan-Mode Channel Sequencer

This block drives an external successive-approximation converter in continuous scan mode. A start can come from three places: a software write to the control register, a one-cycle timer pulse, or the rising edge of an asynchronous trigger pin. Each hardware source has its own enable bit. Once running, the block steps through a group of analog channels in ascending order. For each channel it issues a one-cycle convert request with the channel number, then waits for the converter's done pulse and 10-bit result. The result goes into a result register owned by that channel, and the next channel's request follows in the very next cycle.

After the last channel of the group, an end-of-scan flag is set and the scan wraps back to the group's first channel. This repeats until software clears the run bit. Clearing the run bit aborts any conversion in flight and discards its result. A later start always begins again at the group's first channel. An interrupt output is the flag gated by an enable bit.

The register port is a write strobe with address and data, a read strobe, and combinational read data. The control register sits at address 0. The result register of channel c sits at address 8 + c.

Top module: `adc_scan_seq`

## Requirements
- R1: The run bit (control bit 0) is set by a write of 1 to it, by a `tmr_trig` pulse while bit 8 is 1, or by a rising edge of `ext_trig` (synchronised) while bit 9 is 1. A disabled source, or a pin held high after a stop, does not set it.
- R2: Each scan starts on the first channel of the group. The group is control bit 1, and the first channel is 4 × group (channel 0 or channel 4).
- R3: When a conversion's done pulse is accepted, the next channel's `conv_start` is asserted in the following cycle. Within a group, channels go in ascending order.
- R4: The 10-bit result delivered with a done pulse is stored in the register of the converting channel c. It reads back in bits 9:0 at address 8 + c.
- R5: With span field n (control bits 3:2), channels first … first+n are converted. Completing channel first+n sets the end-of-scan flag (control bit 5), and scanning continues with the first channel.
- R6: `scan_irq` is high exactly when the flag is 1 and the interrupt enable (control bit 4) is 1.
- R7: Writing 0 to the run bit stops the sequencer, and no `conv_start` is issued while stopped. A following start begins at the group's first channel, not where the scan halted.
- R8: A done pulse for a conversion aborted by a stop is discarded, and no result register changes.
- R9: Group and span values written in the same write that sets the run bit take effect for that scan. Group and span writes made while running do not change the running scan.
- R10: The flag is cleared only by a control write with bit 5 = 0 that follows a control read which returned the flag as 1. Writing 1 to bit 5, or 0 without that read, leaves it set.
- R11: If the flag is set by an end of scan in the same cycle as a valid clear, it stays set.
- R12: After reset the control register reads 0, all results read 0, and `conv_start` and `scan_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms flag clear) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| tmr_trig | input | 1 | One-cycle timer start pulse |
| ext_trig | input | 1 | Asynchronous external start pin, rising edge |
| conv_start | output | 1 | One-cycle convert request |
| conv_ch | output | 3 | Channel of the request |
| conv_done | input | 1 | Converter done pulse |
| conv_data | input | 10 | Converter result, valid with `conv_done` |
| scan_irq | output | 1 | End-of-scan interrupt request |

## Verification
Two pairs of events can collide in one cycle. The first is the end-of-scan flag being set by the last channel's done pulse while software writes a valid clear. The bench runs a one-channel scan with the converter's done driven by hand. It arms the clear with a read and places the done pulse and the clearing write on the same edge. It then expects the flag to read 1 and the new result to be stored. The second pair is a stop arriving while a conversion is outstanding. The bench holds the converter, halts, then releases the late done pulse and expects the result register to keep its old value.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  // Sequencer phases: idle, one-cycle request, waiting for the converter.
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ISSUE = 2'd1,
    SEQ_WAIT  = 2'd2
  } seq_state_e;

  // Per-source enables for hardware starts.
  typedef struct packed {
    logic tmr;
    logic ext;
  } trig_en_t;

endpackage

// File: rtl/adc_scan_trig.sv
module adc_scan_trig
  import adc_scan_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tmr_pulse_i,
  input  logic     ext_pin_i,
  input  trig_en_t en_i,
  output logic     hw_req_o
);

  // Synchroniser stages plus one extra stage for edge detection.
  logic [SYNC_N:0] sync_q;
  logic            ext_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_N-1:0], ext_pin_i};
  end

  assign ext_rise = sync_q[SYNC_N-1] & ~sync_q[SYNC_N];
  assign hw_req_o = (tmr_pulse_i & en_i.tmr) | (ext_rise & en_i.ext);

  // R1
  trig_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_req_o |-> (en_i.tmr || en_i.ext));

endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
  import adc_scan_pkg::*;
#(
  parameter int GRP_W = 1,
  parameter int IDX_W = 2,
  parameter int RES_W = 10,
  localparam int CH_W = GRP_W + IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_evt_i,
  input  logic             stop_evt_i,
  input  logic [GRP_W-1:0] grp_d_i,
  input  logic [IDX_W-1:0] span_d_i,
  input  logic             conv_done_i,
  input  logic [RES_W-1:0] conv_data_i,
  output logic             conv_start_o,
  output logic [CH_W-1:0]  conv_ch_o,
  output logic             scan_end_o,
  output logic             res_we_o,
  output logic [CH_W-1:0]  res_ch_o,
  output logic [RES_W-1:0] res_data_o
);

  // Absolute channel from group and position in group.
  function automatic logic [CH_W-1:0] chan_of(input logic [GRP_W-1:0] g,
                                              input logic [IDX_W-1:0] i);
    return {g, i};
  endfunction

  // Position i is the last one of a group of span+1 channels.
  function automatic logic is_last(input logic [IDX_W-1:0] i,
                                   input logic [IDX_W-1:0] span);
    return i == span;
  endfunction

  seq_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic [GRP_W-1:0] grp_a_q;
  logic [IDX_W-1:0] span_a_q;
  logic             done_acc;

  // A done pulse counts only while waiting and not in the stop cycle.
  assign done_acc     = (state_q == SEQ_WAIT) && conv_done_i && !stop_evt_i;
  assign conv_start_o = (state_q == SEQ_ISSUE);
  assign conv_ch_o    = chan_of(grp_a_q, idx_q);
  assign res_we_o     = done_acc;
  assign res_ch_o     = chan_of(grp_a_q, idx_q);
  assign res_data_o   = conv_data_i;
  assign scan_end_o   = done_acc && is_last(idx_q, span_a_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      idx_q    <= '0;
      grp_a_q  <= '0;
      span_a_q <= '0;
    end else if (stop_evt_i) begin
      state_q <= SEQ_IDLE;
    end else if (start_evt_i) begin
      state_q  <= SEQ_ISSUE;
      idx_q    <= '0;
      grp_a_q  <= grp_d_i;
      span_a_q <= span_d_i;
    end else begin
      case (state_q)
        SEQ_ISSUE: state_q <= SEQ_WAIT;
        SEQ_WAIT: if (done_acc) begin
          state_q <= SEQ_ISSUE;
          idx_q   <= is_last(idx_q, span_a_q) ? '0 : idx_q + IDX_W'(1);
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  // R3
  next_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_acc |=> conv_start_o);

  // R2
  first_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt_i |=> (conv_start_o && conv_ch_o[IDX_W-1:0] == '0 &&
                     conv_ch_o[CH_W-1:IDX_W] == $past(grp_d_i)));

  // R5
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_end_o |=> (conv_ch_o[IDX_W-1:0] == '0));

endmodule

// File: rtl/adc_scan_regs.sv
module adc_scan_regs
  import adc_scan_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int RES_W  = 10,
  parameter int GRP_W  = 1,
  parameter int IDX_W  = 2,
  localparam int CH_W    = GRP_W + IDX_W,
  localparam int NCH     = 2 ** CH_W,
  localparam int ADDR_W  = CH_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              hw_req_i,
  input  logic              scan_end_i,
  input  logic              res_we_i,
  input  logic [CH_W-1:0]   res_ch_i,
  input  logic [RES_W-1:0]  res_data_i,
  output logic              start_evt_o,
  output logic              stop_evt_o,
  output logic [GRP_W-1:0]  grp_d_o,
  output logic [IDX_W-1:0]  span_d_o,
  output trig_en_t          trig_en_o,
  output logic              irq_o
);

  // Control field positions, derived from the group and span widths.
  localparam int RUN_B   = 0;
  localparam int GRP_LO  = 1;
  localparam int SPAN_LO = GRP_LO + GRP_W;
  localparam int IEN_B   = SPAN_LO + IDX_W;
  localparam int FLAG_B  = IEN_B + 1;
  localparam int TEN_B   = 8;
  localparam int XEN_B   = 9;

  logic             run_q, run_d;
  logic [GRP_W-1:0] grp_q;
  logic [IDX_W-1:0] span_q;
  logic             ien_q, flag_q, flag_d, armed_q;
  logic             ten_q, xen_q;
  logic             ctrl_hit, ctrl_wr, ctrl_rd, clr_ok;
  logic [RES_W-1:0] res_q [NCH];
  logic             unused_wbits;

  assign unused_wbits = ^{wdata_i[DATA_W-1:XEN_B+1], wdata_i[TEN_B-1:FLAG_B+1]};

  assign ctrl_hit = (addr_i == '0);
  assign ctrl_wr  = wr_i & ctrl_hit;
  assign ctrl_rd  = rd_i & ctrl_hit;

  // Software write wins over a hardware start in the same cycle.
  assign run_d    = ctrl_wr ? wdata_i[RUN_B] : (run_q | hw_req_i);
  assign grp_d_o  = ctrl_wr ? wdata_i[GRP_LO +: GRP_W] : grp_q;
  assign span_d_o = ctrl_wr ? wdata_i[SPAN_LO +: IDX_W] : span_q;

  assign start_evt_o = run_d & ~run_q;
  assign stop_evt_o  = run_q & ~run_d;

  // Flag: set has priority over the armed clear.
  assign clr_ok = ctrl_wr & ~wdata_i[FLAG_B] & armed_q;
  assign flag_d = scan_end_i ? 1'b1 : (clr_ok ? 1'b0 : flag_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      grp_q   <= '0;
      span_q  <= '0;
      ien_q   <= 1'b0;
      ten_q   <= 1'b0;
      xen_q   <= 1'b0;
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      grp_q  <= grp_d_o;
      span_q <= span_d_o;
      flag_q <= flag_d;
      if (ctrl_wr) begin
        ien_q <= wdata_i[IEN_B];
        ten_q <= wdata_i[TEN_B];
        xen_q <= wdata_i[XEN_B];
      end
      if (clr_ok)                armed_q <= 1'b0;
      else if (ctrl_rd && flag_q) armed_q <= 1'b1;
    end
  end

  // One result register per channel.
  for (genvar c = 0; c < NCH; c++) begin : g_res
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     res_q[c] <= '0;
      else if (res_we_i && res_ch_i == CH_W'(c))      res_q[c] <= res_data_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (ctrl_hit) begin
      rdata_o[RUN_B]             = run_q;
      rdata_o[GRP_LO +: GRP_W]   = grp_q;
      rdata_o[SPAN_LO +: IDX_W]  = span_q;
      rdata_o[IEN_B]             = ien_q;
      rdata_o[FLAG_B]            = flag_q;
      rdata_o[TEN_B]             = ten_q;
      rdata_o[XEN_B]             = xen_q;
    end else if (addr_i[ADDR_W-1]) begin
      rdata_o[RES_W-1:0] = res_q[addr_i[CH_W-1:0]];
    end
  end

  assign trig_en_o.tmr = ten_q;
  assign trig_en_o.ext = xen_q;
  assign irq_o         = flag_q & ien_q;

  // R11
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_end_i |=> flag_q);

  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(armed_q));

  // R8
  no_store_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !res_we_i);

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int RES_W  = 10,
  parameter int GRP_W  = 1,
  parameter int IDX_W  = 2,
  parameter int SYNC_N = 2,
  localparam int CH_W   = GRP_W + IDX_W,
  localparam int ADDR_W = CH_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tmr_trig,
  input  logic              ext_trig,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_ch,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_data,
  output logic              scan_irq
);

  logic             hw_req, start_evt, stop_evt, scan_end, res_we;
  logic [GRP_W-1:0] grp_d;
  logic [IDX_W-1:0] span_d;
  logic [CH_W-1:0]  res_ch;
  logic [RES_W-1:0] res_data;
  trig_en_t         trig_en;

  adc_scan_trig #(.SYNC_N(SYNC_N)) u_trig (
    .clk(clk), .rst_n(rst_n), .tmr_pulse_i(tmr_trig), .ext_pin_i(ext_trig),
    .en_i(trig_en), .hw_req_o(hw_req)
  );

  adc_scan_regs #(.DATA_W(DATA_W), .RES_W(RES_W), .GRP_W(GRP_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .rd_i(bus_rd), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .rdata_o(bus_rdata), .hw_req_i(hw_req),
    .scan_end_i(scan_end), .res_we_i(res_we), .res_ch_i(res_ch),
    .res_data_i(res_data), .start_evt_o(start_evt), .stop_evt_o(stop_evt),
    .grp_d_o(grp_d), .span_d_o(span_d), .trig_en_o(trig_en), .irq_o(scan_irq)
  );

  adc_scan_fsm #(.GRP_W(GRP_W), .IDX_W(IDX_W), .RES_W(RES_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_evt_i(start_evt), .stop_evt_i(stop_evt),
    .grp_d_i(grp_d), .span_d_i(span_d), .conv_done_i(conv_done),
    .conv_data_i(conv_data), .conv_start_o(conv_start), .conv_ch_o(conv_ch),
    .scan_end_o(scan_end), .res_we_o(res_we), .res_ch_o(res_ch),
    .res_data_o(res_data)
  );

  // R7
  halted_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && $past(stop_evt)) |-> 1'b0);

endmodule

// File: tb/test_adc_scan_seq.sv
`timescale 1ns/1ps
module test_adc_scan_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        tmr_trig = 1'b0, ext_trig = 1'b0;
  logic        conv_start;
  logic [2:0]  conv_ch;
  logic        conv_done;
  logic [9:0]  conv_data;
  logic        scan_irq;

  always #4 clk = ~clk;

  adc_scan_seq i_adc_scan_seq (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tmr_trig(tmr_trig), .ext_trig(ext_trig), .conv_start(conv_start),
    .conv_ch(conv_ch), .conv_done(conv_done), .conv_data(conv_data),
    .scan_irq(scan_irq)
  );

  int n_chk = 0, n_fail = 0;

  // Converter model: fixed latency, optional hold, manual override.
  logic       man_mode = 1'b0, man_done = 1'b0;
  logic [9:0] man_data = '0;
  logic       hold = 1'b0, orphan_ok = 1'b0, tb_run = 1'b0;
  logic       busy = 1'b0, auto_done = 1'b0;
  logic [9:0] auto_data = '0;
  logic [2:0] pch = '0;
  int         cnt = 0, seq = 0;
  logic [9:0] exp_res [8];
  logic [2:0] log_ch [256];
  int         log_n = 0;

  assign conv_done = man_mode ? man_done : auto_done;
  assign conv_data = man_mode ? man_data : auto_data;

  always @(posedge clk) begin
    auto_done <= 1'b0;
    if (conv_start) begin
      busy <= 1'b1; cnt <= 3; pch <= conv_ch;
      log_ch[log_n % 256] <= conv_ch;
      log_n <= log_n + 1;
    end else if (busy && !tb_run && !orphan_ok) begin
      busy <= 1'b0;
    end else if (busy && !hold) begin
      if (cnt == 0) begin
        auto_done <= 1'b1;
        auto_data <= {pch, 7'(seq)};
        exp_res[pch] <= {pch, 7'(seq)};
        seq <= seq + 1;
        busy <= 1'b0;
      end else cnt <= cnt - 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    if (a == 4'd0) tb_run = d[0];
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_log(input int target, input string req);
    int k = 0;
    while (log_n < target && k < 3000) begin @(negedge clk); k++; end
    if (log_n < target) check(req, log_n, target);
  endtask

  // Halt with the converter frozen so no result is in flight.
  task automatic halt(input logic [15:0] v);
    hold = 1'b1;
    idle(3);
    wr(4'd0, v);
    idle(2);
    hold = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(4'd0, d);  check("R12 ctrl", d, 16'h0);
    rd(4'd8, d);  check("R12 result", d, 16'h0);
    check("R12 conv_start", conv_start, 1'b0);
    check("R12 irq", scan_irq, 1'b0);
  endtask

  task automatic t_basic_scan();
    int base = log_n, k = 0;
    logic [15:0] d;
    wr(4'd0, 16'h0039);                 // run, group 0, span 2, irq enable
    while (!scan_irq && k < 3000) begin @(negedge clk); k++; end
    check("R6 irq on end of scan", scan_irq, 1'b1);
    check("R2 first channel", log_ch[base % 256], 3'd0);
    check("R3 second channel", log_ch[(base + 1) % 256], 3'd1);
    check("R3 third channel", log_ch[(base + 2) % 256], 3'd2);
    wait_log(base + 4, "R5 wrap");
    check("R5 wrap to first", log_ch[(base + 3) % 256], 3'd0);
    halt(16'h0038);
    for (int c = 0; c < 3; c++) begin
      rd(4'(8 + c), d);
      check("R4 result per channel", d, {6'd0, exp_res[c]});
    end
  endtask

  task automatic t_flag_clear();
    logic [15:0] d;
    wr(4'd0, 16'h0018);                 // clear attempt without prior read
    rd(4'd0, d);  check("R10 clear needs read", d, 16'h0038);
    wr(4'd0, 16'h0038);                 // write 1 to flag
    rd(4'd0, d);  check("R10 write one no effect", d, 16'h0038);
    wr(4'd0, 16'h0018);
    rd(4'd0, d);  check("R10 armed clear", d, 16'h0018);
    check("R6 irq low after clear", scan_irq, 1'b0);
  endtask

  task automatic t_config();
    int base = log_n;
    wr(4'd0, 16'h0027);                 // run with group 1, span 1 in one write
    wait_log(base + 3, "R9 start");
    check("R9 same-write group", log_ch[base % 256], 3'd4);
    check("R9 same-write span", log_ch[(base + 1) % 256], 3'd5);
    check("R9 span wraps", log_ch[(base + 2) % 256], 3'd4);
    wr(4'd0, 16'h002B);                 // span 2 while running
    wait_log(base + 7, "R9 running");
    for (int i = 3; i < 7; i++)
      check("R9 running scan unchanged", log_ch[(base + i) % 256], (i % 2 == 1) ? 3'd5 : 3'd4);
    halt(16'h002A);
  endtask

  task automatic t_restart();
    int base = log_n, n0;
    wr(4'd0, 16'h002B);
    wait_log(base + 2, "R7 run");
    halt(16'h002A);
    n0 = log_n;
    idle(10);
    check("R7 quiet while stopped", log_n, n0);
    base = log_n;
    wr(4'd0, 16'h002B);
    wait_log(base + 1, "R7 restart");
    check("R7 restart at first channel", log_ch[base % 256], 3'd4);
    halt(16'h002A);
  endtask

  task automatic t_group1_results();
    int base = log_n;
    logic [15:0] d;
    wr(4'd0, 16'h002F);                 // group 1, span 3
    wait_log(base + 5, "R4 group 1");
    halt(16'h002E);
    for (int c = 4; c < 8; c++) begin
      rd(4'(8 + c), d);
      check("R4 group 1 result", d, {6'd0, exp_res[c]});
    end
    rd(4'd0, d);
    check("R5 flag after full scan", d[5], 1'b1);
  endtask

  task automatic t_triggers();
    int base;
    logic [15:0] d;
    wr(4'd0, 16'h0020);                 // stopped, group 0, span 0, no enables
    @(negedge clk); tmr_trig = 1'b1; @(negedge clk); tmr_trig = 1'b0;
    idle(4);
    rd(4'd0, d);  check("R1 timer disabled", d[0], 1'b0);
    ext_trig = 1'b1; idle(6);
    rd(4'd0, d);  check("R1 pin disabled", d[0], 1'b0);
    ext_trig = 1'b0; idle(4);
    wr(4'd0, 16'h0320);                 // enable both sources
    base = log_n;
    tb_run = 1'b1;
    @(negedge clk); tmr_trig = 1'b1; @(negedge clk); tmr_trig = 1'b0;
    idle(3);
    rd(4'd0, d);  check("R1 timer start", d[0], 1'b1);
    check("R1 R2 timer scan channel", log_ch[base % 256], 3'd0);
    halt(16'h0320);
    tb_run = 1'b1;
    ext_trig = 1'b1; idle(6);
    rd(4'd0, d);  check("R1 pin edge start", d[0], 1'b1);
    halt(16'h0320);
    idle(6);
    rd(4'd0, d);  check("R1 held pin no restart", d[0], 1'b0);
    ext_trig = 1'b0;
    wr(4'd0, 16'h0020);
  endtask

  task automatic t_same_cycle();
    logic [15:0] d;
    rd(4'd0, d);                        // arms clear if flag is set
    wr(4'd0, 16'h0000);
    rd(4'd0, d);  check("R10 cleared before test", d, 16'h0000);
    man_mode = 1'b1;
    wr(4'd0, 16'h0021);                 // run, group 0, span 0, no irq enable
    idle(3);
    @(negedge clk); man_done = 1'b1; man_data = 10'h155;
    @(negedge clk); man_done = 1'b0;
    check("R6 irq masked", scan_irq, 1'b0);
    rd(4'd0, d);  check("R5 single-channel flag", d[5], 1'b1);
    rd(4'd8, d);  check("R4 manual result", d, 16'h0155);
    @(negedge clk);                     // sequencer is waiting again
    man_done = 1'b1; man_data = 10'h0AA;
    bus_wr = 1'b1; bus_addr = 4'd0; bus_wdata = 16'h0001;
    @(negedge clk);
    man_done = 1'b0; bus_wr = 1'b0;
    rd(4'd0, d);  check("R11 set wins over clear", d, 16'h0021);
    rd(4'd8, d);  check("R11 result stored", d, 16'h00AA);
    wr(4'd0, 16'h0001);
    rd(4'd0, d);  check("R10 clear after read", d, 16'h0001);
    wr(4'd0, 16'h0000);
    man_mode = 1'b0;
  endtask

  task automatic t_abort();
    int n0;
    logic [15:0] d, snap;
    idle(8);
    rd(4'd8, snap);
    hold = 1'b1; orphan_ok = 1'b1;
    wr(4'd0, 16'h0021);
    idle(5);
    wr(4'd0, 16'h0020);
    idle(2);
    n0 = log_n;
    hold = 1'b0;
    idle(12);
    rd(4'd8, d);  check("R8 aborted result discarded", d, snap);
    check("R8 no new request", log_n, n0);
    orphan_ok = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 8; c++) exp_res[c] = '0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_basic_scan();
    t_flag_clear();
    t_config();
    t_restart();
    t_group1_results();
    t_triggers();
    t_same_cycle();
    t_abort();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule